// File: doc/BRIEF.md
# Maintenance Bit Change Filter

Every basic line frame carries a few overhead bits next to its payload: a three-bit embedded-operations message, one M4 bit and two spare bits (M5 and M6). This block watches those bits frame by frame. It passes a change on to the system side only after the change has proven stable. A value counts as confirmed once it has arrived in three consecutive frames with the same content. Only a confirmed value that differs from the value last reported produces a report strobe. A receiver that has lost synchronisation produces nothing, and losing sync restarts every persistence count.

The operations message and the M4 bit each have their own mode inputs. The operations message is either filtered or passed through untouched on every frame. The M4 bit can be filtered, passed through, or filtered with an extra condition: the superframe CRC must also be good. In that case a confirmed M4 change waits until the next CRC verdict strobe. A good verdict releases it. A bad verdict discards it and restarts the persistence count. The two spare bits are filtered independently of each other.

Each report is registered. Its strobe is high for one cycle, in the cycle after the clock edge that sampled the causing frame or CRC strobe.

Top module: `maint_bit_filter`

## Requirements
- R1: With `eoc_transparent`=0, an operations message held in three consecutive frame strobes raises `eoc_rpt_vld` for one cycle after the third strobe, with `eoc_rpt` equal to that message. The first and second strobes raise nothing.
- R2: In a filtered channel, a confirmed value equal to the last reported value produces no strobe. This covers further repeats of a reported value and the all-zero value present after reset.
- R3: A frame carrying a different value restarts the run of identical frames, so a value needs three uninterrupted consecutive copies.
- R4: With `eoc_transparent`=1, every frame strobe received while in sync produces an `eoc_rpt_vld` strobe carrying that frame's message, whether or not it repeats.
- R5: With `m4_transparent`=0 and `m4_use_crc`=0, the M4 bit follows the same three-frame rule and reports on `m4_rpt_vld`/`m4_rpt`.
- R6: With `m4_use_crc`=1 (and `m4_transparent`=0), a confirmed M4 change produces no strobe at the frame. It is reported one cycle after the next `crc_vld` strobe that carries `crc_ok`=1.
- R7: In CRC mode, a `crc_vld` strobe with `crc_ok`=0 discards any pending M4 change and restarts the M4 run. Three new consecutive frames and then a good CRC verdict are needed before the change is reported.
- R8: With `m4_transparent`=1, every in-sync frame strobe reports the frame's M4 bit.
- R9: Bit 0 of `spare_bits` (M5) and bit 1 (M6) are validated independently. Each reports through its own bit of `spare_rpt_vld`, with its value on the same bit of `spare_rpt`.
- R10: While `rx_sync`=0, no report strobe is raised in any mode and all runs restart. After sync returns, a value seen twice before the loss still needs three more frames.
- R11: After reset, all report strobes and report values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sync | input | 1 | Receiver frame synchronisation flag |
| frame_vld | input | 1 | One-cycle strobe per basic frame; overhead bits valid |
| eoc_bits | input | 3 | Embedded-operations message of the frame |
| m4_bit | input | 1 | M4 bit of the frame |
| spare_bits | input | 2 | Spare bits of the frame, bit 0 = M5, bit 1 = M6 |
| crc_vld | input | 1 | One-cycle strobe carrying the superframe CRC verdict |
| crc_ok | input | 1 | 1 = superframe CRC matched |
| eoc_transparent | input | 1 | 1 = pass every operations message through |
| m4_transparent | input | 1 | 1 = pass every M4 bit through |
| m4_use_crc | input | 1 | 1 = confirmed M4 changes also need a good CRC |
| eoc_rpt_vld | output | 1 | Operations message report strobe |
| eoc_rpt | output | 3 | Reported operations message |
| m4_rpt_vld | output | 1 | M4 report strobe |
| m4_rpt | output | 1 | Reported M4 value |
| spare_rpt_vld | output | 2 | Per-bit spare report strobes |
| spare_rpt | output | 2 | Reported spare bit values |

## Verification
The hardest state to reach is a confirmed M4 change that a bad CRC verdict throws away. The stimulus must first build a full three-frame run in CRC mode, then deliver the failing verdict, then show that a good verdict right afterwards releases nothing. Only after that does it rebuild the run from zero. A second subtle case is a run broken by loss of sync with two copies already counted. The bench drives exactly two frames, drops `rx_sync` for one frame, and then expects silence for two further frames before the report.

// File: rtl/mbf_pkg.sv
// Shared definitions for the maintenance bit change filter.
package mbf_pkg;
    localparam int unsigned EOC_W_DEF   = 3;
    localparam int unsigned SPARE_N_DEF = 2;
    localparam int unsigned PERSIST_DEF = 3;

    // Per-channel operating mode.
    typedef struct packed {
        logic transparent; // pass every frame through
        logic gate_en;     // hold confirmed values for a good CRC verdict
    } chan_mode_t;
endpackage

// File: rtl/mbf_persist.sv
// Persistence counter: tracks the candidate value and how many consecutive
// frame strobes carried it. Pulses `hit` on the strobe that completes the
// PERSIST-th identical copy. Assumes PERSIST >= 2 and single-cycle strobes.
module mbf_persist #(
    parameter int unsigned W       = 1,
    parameter int unsigned PERSIST = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         restart,
    input  logic         stb,
    input  logic [W-1:0] din,
    output logic         hit
);
    localparam int unsigned CW = $clog2(PERSIST + 1);

    logic [W-1:0]  cand;
    logic [CW-1:0] cnt;

    // Candidate and run-length update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= '0;
            cnt  <= '0;
        end else if (clr || restart) begin
            cnt <= '0;
        end else if (stb) begin
            if (din != cand) begin
                cand <= din;
                cnt  <= CW'(1);
            end else if (cnt < CW'(PERSIST)) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // Completion of the run on this strobe.
    always_comb begin
        hit = stb && !clr && !restart && (din == cand) && (cnt == CW'(PERSIST - 1));
    end
endmodule

// File: rtl/mbf_report.sv
// Report stage of one channel: compares confirmed values with the last
// reported one, optionally holds them for a CRC verdict, applies the
// transparent bypass and the sync gate, and registers the report strobe.
module mbf_report
    import mbf_pkg::*;
#(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic         stb,
    input  logic [W-1:0] din,
    input  logic         hit,
    input  chan_mode_t   mode,
    input  logic         gate_stb,
    input  logic         gate_ok,
    output logic         restart,
    output logic         rpt_vld,
    output logic [W-1:0] rpt_val
);
    logic [W-1:0] last;
    logic [W-1:0] pend;
    logic         pending;
    logic         gated;
    logic         gate_fire;
    logic         nxt_vld;
    logic [W-1:0] nxt_val;

    // Decode the verdict strobe and choose the next report.
    always_comb begin
        gated     = mode.gate_en && !mode.transparent;
        gate_fire = gated && sync && gate_stb;
        restart   = gate_fire && !gate_ok;
        nxt_vld   = 1'b0;
        nxt_val   = din;
        if (mode.transparent) begin
            nxt_vld = stb && sync;
        end else if (gated) begin
            nxt_vld = gate_fire && gate_ok && pending;
            nxt_val = pend;
        end else begin
            nxt_vld = hit && (din != last);
        end
    end

    // Registered report and last reported value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_vld <= 1'b0;
            rpt_val <= '0;
            last    <= '0;
        end else begin
            rpt_vld <= nxt_vld;
            if (nxt_vld) begin
                rpt_val <= nxt_val;
                last    <= nxt_val;
            end
        end
    end

    // Pending confirmed change waiting for a CRC verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            pend    <= '0;
        end else if (!sync || !gated) begin
            pending <= 1'b0;
        end else begin
            if (gate_fire) begin
                pending <= 1'b0;
            end
            if (hit) begin
                pending <= (din != last);
                pend    <= din;
            end
        end
    end
endmodule

// File: rtl/maint_bit_filter.sv
// Maintenance bit change filter: one persistence/report pair per overhead
// field (operations message, M4, each spare bit). Assumes frame_vld and
// crc_vld are single-cycle strobes in the clk domain.
module maint_bit_filter
    import mbf_pkg::*;
#(
    parameter int unsigned EOC_W   = EOC_W_DEF,
    parameter int unsigned SPARE_N = SPARE_N_DEF,
    parameter int unsigned PERSIST = PERSIST_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_sync,
    input  logic               frame_vld,
    input  logic [EOC_W-1:0]   eoc_bits,
    input  logic               m4_bit,
    input  logic [SPARE_N-1:0] spare_bits,
    input  logic               crc_vld,
    input  logic               crc_ok,
    input  logic               eoc_transparent,
    input  logic               m4_transparent,
    input  logic               m4_use_crc,
    output logic               eoc_rpt_vld,
    output logic [EOC_W-1:0]   eoc_rpt,
    output logic               m4_rpt_vld,
    output logic               m4_rpt,
    output logic [SPARE_N-1:0] spare_rpt_vld,
    output logic [SPARE_N-1:0] spare_rpt
);
    chan_mode_t eoc_mode, m4_mode, spare_mode;
    logic       eoc_hit, eoc_restart;
    logic       m4_hit, m4_restart;
    logic       unsync;

    // Mode mapping per channel.
    always_comb begin
        unsync     = !rx_sync;
        eoc_mode   = '{transparent: eoc_transparent, gate_en: 1'b0};
        m4_mode    = '{transparent: m4_transparent,  gate_en: m4_use_crc};
        spare_mode = '{transparent: 1'b0,            gate_en: 1'b0};
    end

    mbf_persist #(.W(EOC_W), .PERSIST(PERSIST)) u_eoc_pers (
        .clk(clk), .rst_n(rst_n), .clr(unsync), .restart(eoc_restart),
        .stb(frame_vld), .din(eoc_bits), .hit(eoc_hit)
    );

    mbf_report #(.W(EOC_W)) u_eoc_rpt (
        .clk(clk), .rst_n(rst_n), .sync(rx_sync), .stb(frame_vld),
        .din(eoc_bits), .hit(eoc_hit), .mode(eoc_mode),
        .gate_stb(1'b0), .gate_ok(1'b0), .restart(eoc_restart),
        .rpt_vld(eoc_rpt_vld), .rpt_val(eoc_rpt)
    );

    mbf_persist #(.W(1), .PERSIST(PERSIST)) u_m4_pers (
        .clk(clk), .rst_n(rst_n), .clr(unsync), .restart(m4_restart),
        .stb(frame_vld), .din(m4_bit), .hit(m4_hit)
    );

    mbf_report #(.W(1)) u_m4_rpt (
        .clk(clk), .rst_n(rst_n), .sync(rx_sync), .stb(frame_vld),
        .din(m4_bit), .hit(m4_hit), .mode(m4_mode),
        .gate_stb(crc_vld), .gate_ok(crc_ok), .restart(m4_restart),
        .rpt_vld(m4_rpt_vld), .rpt_val(m4_rpt)
    );

    // One independent filter per spare bit.
    for (genvar i = 0; i < SPARE_N; i++) begin : g_spare
        logic hit_i, restart_i;

        mbf_persist #(.W(1), .PERSIST(PERSIST)) u_pers (
            .clk(clk), .rst_n(rst_n), .clr(unsync), .restart(restart_i),
            .stb(frame_vld), .din(spare_bits[i]), .hit(hit_i)
        );

        mbf_report #(.W(1)) u_rpt (
            .clk(clk), .rst_n(rst_n), .sync(rx_sync), .stb(frame_vld),
            .din(spare_bits[i]), .hit(hit_i), .mode(spare_mode),
            .gate_stb(1'b0), .gate_ok(1'b0), .restart(restart_i),
            .rpt_vld(spare_rpt_vld[i]), .rpt_val(spare_rpt[i])
        );
    end
endmodule

// File: rtl/maint_bit_filter_chk.sv
// Checker for maint_bit_filter, built on its ports only and bound below.
module maint_bit_filter_chk #(
    parameter int unsigned EOC_W   = 3,
    parameter int unsigned SPARE_N = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_sync,
    input logic               frame_vld,
    input logic [EOC_W-1:0]   eoc_bits,
    input logic               m4_bit,
    input logic [SPARE_N-1:0] spare_bits,
    input logic               crc_vld,
    input logic               crc_ok,
    input logic               eoc_transparent,
    input logic               m4_transparent,
    input logic               m4_use_crc,
    input logic               eoc_rpt_vld,
    input logic [EOC_W-1:0]   eoc_rpt,
    input logic               m4_rpt_vld,
    input logic               m4_rpt,
    input logic [SPARE_N-1:0] spare_rpt_vld,
    input logic [SPARE_N-1:0] spare_rpt
);
    logic [EOC_W-1:0]   eoc_prev;
    logic [SPARE_N-1:0] spare_prev;

    // Shadow of the last values seen on the report ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_prev   <= '0;
            spare_prev <= '0;
        end else begin
            if (eoc_rpt_vld) eoc_prev <= eoc_rpt;
            for (int i = 0; i < SPARE_N; i++) begin
                if (spare_rpt_vld[i]) spare_prev[i] <= spare_rpt[i];
            end
        end
    end

    p_no_rpt_unsync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_rpt_vld || m4_rpt_vld || (spare_rpt_vld != '0)) |-> $past(rx_sync));

    p_eoc_needs_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_rpt_vld |-> $past(frame_vld));

    p_eoc_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sync && frame_vld && eoc_transparent) |=> (eoc_rpt_vld && (eoc_rpt == $past(eoc_bits))));

    p_eoc_change_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_rpt_vld && !$past(eoc_transparent)) |-> (eoc_rpt != eoc_prev));

    p_m4_crc_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m4_rpt_vld && $past(m4_use_crc) && !$past(m4_transparent)) |-> ($past(crc_vld) && $past(crc_ok)));

    p_spare_change_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((spare_rpt ^ spare_prev) & spare_rpt_vld) == spare_rpt_vld));
endmodule

bind maint_bit_filter maint_bit_filter_chk #(.EOC_W(EOC_W), .SPARE_N(SPARE_N)) u_chk (.*);

// File: tb/maint_bit_filter_test.sv
module maint_bit_filter_test;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sync = 1'b1;
    logic       frame_vld = 1'b0;
    logic [2:0] eoc_bits = '0;
    logic       m4_bit = 1'b0;
    logic [1:0] spare_bits = '0;
    logic       crc_vld = 1'b0;
    logic       crc_ok = 1'b0;
    logic       eoc_transparent = 1'b0;
    logic       m4_transparent = 1'b0;
    logic       m4_use_crc = 1'b0;
    logic       eoc_rpt_vld;
    logic [2:0] eoc_rpt;
    logic       m4_rpt_vld;
    logic       m4_rpt;
    logic [1:0] spare_rpt_vld;
    logic [1:0] spare_rpt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    maint_bit_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .frame_vld(frame_vld),
        .eoc_bits(eoc_bits), .m4_bit(m4_bit), .spare_bits(spare_bits),
        .crc_vld(crc_vld), .crc_ok(crc_ok), .eoc_transparent(eoc_transparent),
        .m4_transparent(m4_transparent), .m4_use_crc(m4_use_crc),
        .eoc_rpt_vld(eoc_rpt_vld), .eoc_rpt(eoc_rpt), .m4_rpt_vld(m4_rpt_vld),
        .m4_rpt(m4_rpt), .spare_rpt_vld(spare_rpt_vld), .spare_rpt(spare_rpt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One frame strobe; outputs are sampled at the following falling edge.
    task automatic frame(input logic [2:0] e, input logic m4, input logic [1:0] sp);
        @(negedge clk);
        eoc_bits = e; m4_bit = m4; spare_bits = sp; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
    endtask

    task automatic crc(input logic ok);
        @(negedge clk);
        crc_ok = ok; crc_vld = 1'b1;
        @(negedge clk);
        crc_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 eoc_rpt_vld", eoc_rpt_vld, 0);
        chk("R11 m4_rpt_vld", m4_rpt_vld, 0);
        chk("R11 spare_rpt_vld", spare_rpt_vld, 0);
        chk("R11 eoc_rpt", eoc_rpt, 0);
    endtask

    task automatic t_eoc_filter;
        frame(3'd5, 1'b0, 2'b00); chk("R1 first copy", eoc_rpt_vld, 0);
        frame(3'd5, 1'b0, 2'b00); chk("R1 second copy", eoc_rpt_vld, 0);
        frame(3'd5, 1'b0, 2'b00); chk("R1 third copy vld", eoc_rpt_vld, 1);
        chk("R1 third copy value", eoc_rpt, 5);
        chk("R2 reset m4 value unreported", m4_rpt_vld, 0);
        frame(3'd5, 1'b0, 2'b00); chk("R2 repeat silent", eoc_rpt_vld, 0);
    endtask

    task automatic t_eoc_interrupt;
        frame(3'd2, 1'b0, 2'b00);
        frame(3'd2, 1'b0, 2'b00);
        frame(3'd6, 1'b0, 2'b00); chk("R3 interrupt", eoc_rpt_vld, 0);
        frame(3'd2, 1'b0, 2'b00);
        frame(3'd2, 1'b0, 2'b00); chk("R3 run not complete", eoc_rpt_vld, 0);
        frame(3'd2, 1'b0, 2'b00); chk("R3 run complete", eoc_rpt_vld, 1);
        chk("R3 value", eoc_rpt, 2);
    endtask

    task automatic t_eoc_transparent;
        eoc_transparent = 1'b1;
        frame(3'd2, 1'b0, 2'b00); chk("R4 repeat passes", eoc_rpt_vld, 1);
        frame(3'd7, 1'b0, 2'b00); chk("R4 single copy passes", eoc_rpt_vld, 1);
        chk("R4 value", eoc_rpt, 7);
        frame(3'd2, 1'b0, 2'b00); chk("R4 back value", eoc_rpt, 2);
        eoc_transparent = 1'b0;
    endtask

    task automatic t_m4_plain;
        frame(3'd2, 1'b1, 2'b00);
        frame(3'd2, 1'b1, 2'b00); chk("R5 second copy", m4_rpt_vld, 0);
        frame(3'd2, 1'b1, 2'b00); chk("R5 third copy", m4_rpt_vld, 1);
        chk("R5 value", m4_rpt, 1);
    endtask

    task automatic t_m4_crc_good;
        m4_use_crc = 1'b1;
        frame(3'd2, 1'b0, 2'b00);
        frame(3'd2, 1'b0, 2'b00);
        frame(3'd2, 1'b0, 2'b00); chk("R6 no report at frame", m4_rpt_vld, 0);
        crc(1'b1); chk("R6 released by good crc", m4_rpt_vld, 1);
        chk("R6 value", m4_rpt, 0);
        crc(1'b1); chk("R6 single release", m4_rpt_vld, 0);
    endtask

    task automatic t_m4_crc_bad;
        frame(3'd2, 1'b1, 2'b00);
        frame(3'd2, 1'b1, 2'b00);
        frame(3'd2, 1'b1, 2'b00);
        crc(1'b0); chk("R7 bad crc silent", m4_rpt_vld, 0);
        crc(1'b1); chk("R7 pending discarded", m4_rpt_vld, 0);
        frame(3'd2, 1'b1, 2'b00);
        frame(3'd2, 1'b1, 2'b00);
        crc(1'b1); chk("R7 run restarted", m4_rpt_vld, 0);
        frame(3'd2, 1'b1, 2'b00);
        crc(1'b1); chk("R7 release after new run", m4_rpt_vld, 1);
        chk("R7 value", m4_rpt, 1);
        m4_use_crc = 1'b0;
    endtask

    task automatic t_m4_transparent;
        m4_transparent = 1'b1;
        frame(3'd2, 1'b1, 2'b00); chk("R8 repeat passes", m4_rpt_vld, 1);
        frame(3'd2, 1'b0, 2'b00); chk("R8 single copy passes", m4_rpt_vld, 1);
        chk("R8 value", m4_rpt, 0);
        m4_transparent = 1'b0;
    endtask

    task automatic t_spare;
        frame(3'd2, 1'b0, 2'b01);
        frame(3'd2, 1'b0, 2'b01);
        frame(3'd2, 1'b0, 2'b11); chk("R9 M5 only", spare_rpt_vld, 1);
        chk("R9 M5 value", spare_rpt[0], 1);
        frame(3'd2, 1'b0, 2'b11); chk("R9 quiet", spare_rpt_vld, 0);
        frame(3'd2, 1'b0, 2'b11); chk("R9 M6 only", spare_rpt_vld, 2);
        chk("R9 M6 value", spare_rpt[1], 1);
    endtask

    task automatic t_sync;
        frame(3'd3, 1'b0, 2'b11);
        frame(3'd3, 1'b0, 2'b11);
        rx_sync = 1'b0;
        frame(3'd3, 1'b0, 2'b11); chk("R10 unsync silent", eoc_rpt_vld, 0);
        rx_sync = 1'b1;
        frame(3'd3, 1'b0, 2'b11); chk("R10 restart 1", eoc_rpt_vld, 0);
        frame(3'd3, 1'b0, 2'b11); chk("R10 restart 2", eoc_rpt_vld, 0);
        frame(3'd3, 1'b0, 2'b11); chk("R10 restart 3", eoc_rpt_vld, 1);
        chk("R10 value", eoc_rpt, 3);
        rx_sync = 1'b0; eoc_transparent = 1'b1; m4_transparent = 1'b1;
        frame(3'd4, 1'b1, 2'b11);
        chk("R10 transparent eoc unsync", eoc_rpt_vld, 0);
        chk("R10 transparent m4 unsync", m4_rpt_vld, 0);
        rx_sync = 1'b1; eoc_transparent = 1'b0; m4_transparent = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_eoc_filter();
        t_eoc_interrupt();
        t_eoc_transparent();
        t_m4_plain();
        t_m4_crc_good();
        t_m4_crc_bad();
        t_m4_transparent();
        t_spare();
        t_sync();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule